// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command pins of a single-rank SDR SDRAM from reset until the memory is ready for normal traffic. While the supply is not yet reported stable, it holds every pin low so that no current is pushed into an unpowered device. Once the power-stable input is sampled high, it raises clock-enable and the data mask. The data outputs of the memory therefore stay high-impedance on a shared bus for the whole bring-up.

After a stabilization wait of at least 200 µs, the block issues its commands in a fixed order, each one separated from the previous one by its minimum spacing. The order is precharge of all banks, then a configurable number of auto-refresh commands (never fewer than eight), then a mode register set carrying the caller's mode word. A settle time after that, it raises a sticky init-done flag. The surrounding memory controller takes over the pins once the flag is seen. The wait length is computed from a clock-frequency parameter. All command spacings are parameters.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is high, and in every cycle before the power-stable input has been sampled high, all outputs are 0: clock-enable, data mask, the four command strobes, address, bank address and init-done.
- R2: In the cycle after power-stable is first sampled high, clock-enable and data mask go to 1. They stay 1 through initialization and afterwards, until reset.
- R3: After clock-enable rises, exactly CLK_MHZ*STABLE_US cycles of NOP pass before the first command. NOP is (cs_n, ras_n, cas_n, we_n) = 0111 and is driven in every non-command cycle.
- R4: The first command is precharge-all: strobes 0010, address bit 10 set, all other address bits 0, bank address 0.
- R5: The first auto-refresh follows the precharge by exactly T_RP cycles.
- R6: Exactly N_REF auto-refresh commands are issued, with strobes 0001 and address and bank 0. N_REF is at least 8, and consecutive refreshes are T_RC cycles apart.
- R7: A mode register set follows the last refresh by exactly T_RC cycles. It has strobes 0000, address equal to mode_i[ROW_W-1:0] and bank address equal to the top BA_W bits of mode_i.
- R8: init_done_o rises exactly T_MRD cycles after the mode register set cycle and stays 1 until reset. Only NOP is driven after it.
- R9: A synchronous reset at any point, including during refresh or after completion, returns all outputs to the R1 state. A new sequence then starts only when power-stable is sampled high again.
- R10: Once the sequence has started, changes on power-stable have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok_i | input | 1 | Supply reported stable |
| mode_i | input | ROW_W+BA_W | Mode word: low ROW_W bits to address, top BA_W bits to bank address |
| cke_o | output | 1 | Clock enable to memory |
| dqm_o | output | 1 | Data mask to memory |
| cs_n_o | output | 1 | Chip select strobe |
| ras_n_o | output | 1 | Row strobe |
| cas_n_o | output | 1 | Column strobe |
| we_n_o | output | 1 | Write-enable strobe |
| addr_o | output | ROW_W | Address bus |
| ba_o | output | BA_W | Bank address |
| init_done_o | output | 1 | Initialization complete, sticky |

## Verification
The in-RTL properties check the following on every cycle:
- the all-low state whenever clock-enable is low;
- that clock-enable and data mask never drop once raised;
- the minimum spacing from precharge to refresh, between refreshes, and from the last refresh to the mode register set;
- that at least N_REF refreshes precede the mode register set;
- that init-done never falls.

Only the bench scenarios can show the rest. These are the exact length of the stabilization wait, the address and bank values carried by each command, and that a mid-refresh reset discards the partial sequence and waits for power again. They also cover that toggling power-stable after the start changes nothing, which the bench checks against its cycle-by-cycle reference model.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef enum logic [2:0] {
        PH_OFF,
        PH_STAB,
        PH_PRE,
        PH_REF,
        PH_MRS,
        PH_SETTLE,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic    live;
        sd_cmd_e cmd;
        logic    done;
    } ctl_t;

    localparam int PRE_ALL_BIT = 10;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int us_to_cycles(input int mhz, input int us);
        return mhz * us;
    endfunction

endpackage

// File: rtl/sdinit_timer.sv
module sdinit_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

    a_r3_timer_drains: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sdinit_fsm.sv
module sdinit_fsm
    import sdinit_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int WAIT_CYC = 40000,
    parameter int T_RP     = 3,
    parameter int T_RC     = 9,
    parameter int T_MRD    = 2,
    parameter int N_REF    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_ok_i,
    input  logic             zero_i,
    output logic             load_o,
    output logic [CNT_W-1:0] load_val_o,
    output ctl_t             ctl_o
);
    localparam int RC_W = $clog2(N_REF + 1);
    localparam logic [RC_W-1:0] LAST_REF = RC_W'(N_REF - 1);

    phase_e          ph_q, ph_d;
    logic [RC_W-1:0] refs_q;
    logic            ref_inc;

    always_comb begin
        ph_d       = ph_q;
        load_o     = 1'b0;
        load_val_o = '0;
        ref_inc    = 1'b0;
        ctl_o      = '{live: 1'b1, cmd: CMD_NOP, done: 1'b0};
        unique case (ph_q)
            PH_OFF: begin
                ctl_o.live = 1'b0;
                if (pwr_ok_i) begin
                    ph_d       = PH_STAB;
                    load_o     = 1'b1;
                    load_val_o = CNT_W'(WAIT_CYC - 1);
                end
            end
            PH_STAB: if (zero_i) ph_d = PH_PRE;
            PH_PRE: if (zero_i) begin
                ctl_o.cmd  = CMD_PRE;
                ph_d       = PH_REF;
                load_o     = 1'b1;
                load_val_o = CNT_W'(T_RP - 1);
            end
            PH_REF: if (zero_i) begin
                ctl_o.cmd  = CMD_REF;
                load_o     = 1'b1;
                load_val_o = CNT_W'(T_RC - 1);
                if (refs_q == LAST_REF) ph_d = PH_MRS;
                else                    ref_inc = 1'b1;
            end
            PH_MRS: if (zero_i) begin
                ctl_o.cmd  = CMD_MRS;
                ph_d       = PH_SETTLE;
                load_o     = 1'b1;
                load_val_o = CNT_W'(T_MRD - 1);
            end
            PH_SETTLE: if (zero_i) begin
                ph_d       = PH_DONE;
                ctl_o.done = 1'b1;
            end
            PH_DONE: ctl_o.done = 1'b1;
            default: ph_d = PH_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_OFF;
            refs_q <= '0;
        end else begin
            ph_q <= ph_d;
            if (ref_inc) refs_q <= refs_q + 1'b1;
        end
    end

    a_r6_ref_bound: assert property (@(posedge clk) disable iff (rst)
        refs_q <= LAST_REF);
    a_r10_no_return: assert property (@(posedge clk) disable iff (rst)
        (ph_q != PH_OFF) |=> (ph_q != PH_OFF));
endmodule

// File: rtl/sdinit_pins.sv
module sdinit_pins
    import sdinit_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int BA_W  = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  ctl_t                  ctl_i,
    input  logic [ROW_W+BA_W-1:0] mode_i,
    output logic                  cke_o,
    output logic                  dqm_o,
    output logic [3:0]            strobe_o,
    output logic [ROW_W-1:0]      addr_o,
    output logic [BA_W-1:0]       ba_o,
    output logic                  done_o
);
    logic [ROW_W-1:0] addr_d;
    logic [BA_W-1:0]  ba_d;

    always_comb begin
        addr_d = '0;
        ba_d   = '0;
        unique case (ctl_i.cmd)
            CMD_PRE: addr_d[PRE_ALL_BIT] = 1'b1;
            CMD_MRS: begin
                addr_d = mode_i[ROW_W-1:0];
                ba_d   = mode_i[ROW_W+BA_W-1 -: BA_W];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !ctl_i.live) begin
            cke_o    <= 1'b0;
            dqm_o    <= 1'b0;
            strobe_o <= 4'b0000;
            addr_o   <= '0;
            ba_o     <= '0;
            done_o   <= 1'b0;
        end else begin
            cke_o    <= 1'b1;
            dqm_o    <= 1'b1;
            strobe_o <= ctl_i.cmd;
            addr_o   <= addr_d;
            ba_o     <= ba_d;
            done_o   <= ctl_i.done;
        end
    end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdinit_pkg::*;
#(
    parameter int CLK_MHZ   = 200,
    parameter int STABLE_US = 200,
    parameter int T_RP      = 3,
    parameter int T_RC      = 9,
    parameter int T_MRD     = 2,
    parameter int N_REF     = 8,
    parameter int ROW_W     = 13,
    parameter int BA_W      = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pwr_ok_i,
    input  logic [ROW_W+BA_W-1:0] mode_i,
    output logic                  cke_o,
    output logic                  dqm_o,
    output logic                  cs_n_o,
    output logic                  ras_n_o,
    output logic                  cas_n_o,
    output logic                  we_n_o,
    output logic [ROW_W-1:0]      addr_o,
    output logic [BA_W-1:0]       ba_o,
    output logic                  init_done_o
);
    localparam int WAIT_CYC = us_to_cycles(CLK_MHZ, STABLE_US);
    localparam int MAX_LOAD = max2(max2(WAIT_CYC, T_RC), max2(T_RP, T_MRD));
    localparam int CNT_W    = $clog2(MAX_LOAD + 1);

    if (N_REF < 8 || T_RP < 1 || T_RC < 1 || T_MRD < 1 || ROW_W < 11
        || T_RP > 255 || T_RC > 255 || T_MRD > 255) begin : g_bad_cfg
        $error("sdram_init_seq: unsupported parameter set");
    end

    logic             t_zero, t_load;
    logic [CNT_W-1:0] t_val;
    ctl_t             ctl;
    logic [3:0]       strobe;

    sdinit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load_i(t_load), .load_val_i(t_val), .zero_o(t_zero)
    );

    sdinit_fsm #(
        .CNT_W(CNT_W), .WAIT_CYC(WAIT_CYC), .T_RP(T_RP), .T_RC(T_RC),
        .T_MRD(T_MRD), .N_REF(N_REF)
    ) u_fsm (
        .clk(clk), .rst(rst), .pwr_ok_i(pwr_ok_i), .zero_i(t_zero),
        .load_o(t_load), .load_val_o(t_val), .ctl_o(ctl)
    );

    sdinit_pins #(.ROW_W(ROW_W), .BA_W(BA_W)) u_pins (
        .clk(clk), .rst(rst), .ctl_i(ctl), .mode_i(mode_i),
        .cke_o(cke_o), .dqm_o(dqm_o), .strobe_o(strobe), .addr_o(addr_o),
        .ba_o(ba_o), .done_o(init_done_o)
    );

    assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = strobe;

    // Pin-level spacing observer used only by the properties below.
    localparam logic [7:0] RP8  = 8'(T_RP);
    localparam logic [7:0] RC8  = 8'(T_RC);
    localparam logic [7:0] MRD8 = 8'(T_MRD);
    localparam int         NR_W = $clog2(N_REF + 2);

    logic            is_cmd;
    logic [3:0]      last_q;
    logic [7:0]      gap_q;
    logic [NR_W-1:0] nref_q;

    assign is_cmd = cke_o && (strobe != CMD_NOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= CMD_NOP;
            gap_q  <= '0;
            nref_q <= '0;
        end else begin
            if (is_cmd) begin
                last_q <= strobe;
                gap_q  <= 8'd1;
                if (strobe == CMD_REF && nref_q != '1) nref_q <= nref_q + 1'b1;
            end else if (gap_q != 8'hFF) begin
                gap_q <= gap_q + 8'd1;
            end
        end
    end

    a_r1_idle_low: assert property (@(posedge clk) disable iff (rst)
        !cke_o |-> (!dqm_o && !init_done_o && strobe == 4'b0000
                    && addr_o == '0 && ba_o == '0));
    a_r2_cke_hold: assert property (@(posedge clk) disable iff (rst)
        cke_o |=> cke_o);
    a_r2_dqm_with_cke: assert property (@(posedge clk) disable iff (rst)
        cke_o |-> dqm_o);
    a_r4_pre_first: assert property (@(posedge clk) disable iff (rst)
        (is_cmd && strobe == CMD_PRE) |-> (last_q == CMD_NOP && addr_o[PRE_ALL_BIT]));
    a_r5_trp_gap: assert property (@(posedge clk) disable iff (rst)
        (is_cmd && strobe == CMD_REF && last_q == CMD_PRE) |-> (gap_q >= RP8));
    a_r6_trc_gap: assert property (@(posedge clk) disable iff (rst)
        (is_cmd && strobe == CMD_REF && last_q == CMD_REF) |-> (gap_q >= RC8));
    a_r7_mrs_after_refs: assert property (@(posedge clk) disable iff (rst)
        (is_cmd && strobe == CMD_MRS) |->
            (last_q == CMD_REF && gap_q >= RC8 && nref_q >= NR_W'(N_REF)));
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
        init_done_o |=> init_done_o);
    a_r8_done_after_mrs: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done_o) |-> (last_q == CMD_MRS && gap_q >= MRD8));
endmodule

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;
    localparam int CLK_MHZ = 200, STABLE_US = 200, T_RP = 3, T_RC = 9, T_MRD = 2;
    localparam int N_REF = 8, ROW_W = 13, BA_W = 2;
    localparam int WAIT = CLK_MHZ * STABLE_US;
    localparam logic [ROW_W+BA_W-1:0] MODE = 15'b01_0000000110010;
    localparam int EW = 8 + ROW_W + BA_W - 1;

    logic clk = 1'b0, rst = 1'b1, pwr = 1'b0;
    logic cke, dqm, cs_n, ras_n, cas_n, we_n, done;
    logic [ROW_W-1:0] addr;
    logic [BA_W-1:0] ba;

    always #2.5 clk = ~clk;

    sdram_init_seq #(.CLK_MHZ(CLK_MHZ), .STABLE_US(STABLE_US), .T_RP(T_RP), .T_RC(T_RC),
        .T_MRD(T_MRD), .N_REF(N_REF), .ROW_W(ROW_W), .BA_W(BA_W)) u_dut (
        .clk(clk), .rst(rst), .pwr_ok_i(pwr), .mode_i(MODE), .cke_o(cke), .dqm_o(dqm),
        .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
        .addr_o(addr), .ba_o(ba), .init_done_o(done));

    int compared = 0, mismatched = 0, resets = 0, cyc = 0;
    bit finished = 0;

    function automatic logic [EW-1:0] pk(logic c, logic [3:0] s, logic [ROW_W-1:0] a,
                                         logic [BA_W-1:0] b, logic d);
        return {c, c, s, a, b, d};
    endfunction

    localparam logic [EW-1:0] ZERO = '0;
    logic [EW-1:0] exp_q[$];
    logic [EW-1:0] cur, steady;
    bit off = 1;

    task automatic chk(string tag, bit ok, logic [63:0] act, logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    function automatic string tag_of(logic [EW-1:0] e);
        if (!e[EW-1]) return (resets > 1) ? "R9" : "R1";
        if (e[0]) return "R8";
        case (e[EW-3 -: 4])
            4'b0010: return "R4";
            4'b0001: return "R6";
            4'b0000: return "R7";
            default: return "R2,R3,R10";
        endcase
    endfunction

    initial begin
        cur = ZERO;
        steady = ZERO;
    end

    // Reference model compare, every cycle
    always @(negedge clk) begin
        logic [EW-1:0] act;
        act = {cke, dqm, cs_n, ras_n, cas_n, we_n, addr, ba, done};
        chk(tag_of(cur), act === cur, 64'(act), 64'(cur));
        if (rst) begin
            exp_q.delete();
            off = 1;
            steady = ZERO;
        end else if (off && pwr) begin
            off = 0;
            exp_q.push_back(ZERO);
            for (int i = 0; i < WAIT; i++) exp_q.push_back(pk(1, 4'b0111, '0, '0, 0));
            exp_q.push_back(pk(1, 4'b0010, ROW_W'(1) << 10, '0, 0));
            for (int i = 0; i < T_RP - 1; i++) exp_q.push_back(pk(1, 4'b0111, '0, '0, 0));
            for (int r = 0; r < N_REF; r++) begin
                exp_q.push_back(pk(1, 4'b0001, '0, '0, 0));
                for (int i = 0; i < T_RC - 1; i++) exp_q.push_back(pk(1, 4'b0111, '0, '0, 0));
            end
            exp_q.push_back(pk(1, 4'b0000, MODE[ROW_W-1:0], MODE[ROW_W+BA_W-1 -: BA_W], 0));
            for (int i = 0; i < T_MRD - 1; i++) exp_q.push_back(pk(1, 4'b0111, '0, '0, 0));
            steady = pk(1, 4'b0111, '0, '0, 1);
        end
        cur = (exp_q.size() > 0) ? exp_q.pop_front() : steady;
    end

    // Port-level spacing monitor
    int rise_c = -1, last_c = -1, nref = 0;
    logic [3:0] last_s = 4'b0111;
    logic seen_hi = 0, prev_done = 0;
    always @(negedge clk) begin
        logic [3:0] s;
        s = {cs_n, ras_n, cas_n, we_n};
        cyc++;
        if (rst) begin
            rise_c = -1; last_c = -1; nref = 0; last_s = 4'b0111; seen_hi = 0; prev_done = 0;
        end else begin
            if (cke && !seen_hi) begin seen_hi = 1; rise_c = cyc; end
            if (seen_hi && (!cke || !dqm))
                chk("R2", 0, 64'({cke, dqm}), 64'(2'b11));
            if (cke && s != 4'b0111) begin
                if (s == 4'b0010) chk("R3", cyc - rise_c == WAIT, 64'(cyc - rise_c), 64'(WAIT));
                if (s == 4'b0010) chk("R4", addr == (ROW_W'(1) << 10) && ba == 0, 64'({addr, ba}), 64'(1 << 12));
                if (s == 4'b0001 && last_s == 4'b0010) chk("R5", cyc - last_c == T_RP, 64'(cyc - last_c), 64'(T_RP));
                if (s == 4'b0001 && last_s == 4'b0001) chk("R6", cyc - last_c == T_RC, 64'(cyc - last_c), 64'(T_RC));
                if (s == 4'b0001) nref++;
                if (s == 4'b0000) begin
                    chk("R6", nref == N_REF && nref >= 8, 64'(nref), 64'(N_REF));
                    chk("R7", cyc - last_c == T_RC && addr == MODE[ROW_W-1:0]
                        && ba == MODE[ROW_W+BA_W-1 -: BA_W], 64'({addr, ba}), 64'(MODE));
                end
                last_s = s; last_c = cyc;
            end
            if (done && !prev_done) begin
                chk("R8", last_s == 4'b0000 && cyc - last_c == T_MRD, 64'(cyc - last_c), 64'(T_MRD));
                chk("R2", cke && dqm, 64'({cke, dqm}), 64'(2'b11));
            end
            prev_done = done;
        end
    end

    task automatic drive(bit r, bit p);
        @(posedge clk); #1;
        rst = r; pwr = p;
        if (r) resets++;
    endtask

    task automatic run(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic wait_done();
        int k = 0;
        while (!done && k < 50000) begin @(posedge clk); k++; end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        resets = 1;
        run(5);
        drive(0, 0); run(40);              // R1 idle with power low
        drive(0, 1); run(1000);
        drive(0, 0); run(100);             // R10 power drop ignored
        drive(0, 1); wait_done(); run(20); // R8 sticky done
        drive(1, 0); run(3);               // R9 reset after done
        drive(0, 0); run(30);
        drive(0, 1); run(WAIT + T_RP + 2 * T_RC + 5);
        drive(1, 0); run(4);               // R9 reset during refresh
        drive(0, 0); run(30);
        drive(0, 1); wait_done(); run(20);
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog (R8): actual not done expected done");
            summary();
            $finish;
        end
    end
endmodule